// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block lets synchronous logic run program, erase and reset operations on an asynchronous parallel NOR flash bus. The bus is 32 bits wide and is built from four byte-wide devices, each with its own active-low chip select. A host hands over one request at a time: an operation code, a 23-bit address, a data byte and a 4-bit lane mask. The block then plays the unlock-and-command write sequence onto the bus. Every write is a stretched write-enable pulse inside a chip-select window, with address and data held steady over the whole cycle.

After the last command write, the block reads the target address again and again. It looks at bit 7 of every selected lane until each one shows the completed value. If this takes longer than the limit for that operation, the block stops and reports an error. A reset request drives the flash reset line low for the minimum pulse width, then waits out the recovery time before it signals completion.

All minimum bus times are given as nanosecond parameters and turned into clock counts, rounded up. The timeouts are given in microseconds. The host sees an acknowledge pulse when a request is taken, a busy level for the whole operation, and a one-cycle done pulse at the end. A sticky error flag is valid from the done pulse onward.

Top module: `nfs_seq`

## Requirements
- R1: Operation code 0 (byte program) produces exactly four write cycles in this order: AAh at address 5555h, 55h at address 2AAAh, A0h at address 5555h, then the request data at the request address.
- R2: Operation code 1 (sector erase) produces exactly six write cycles: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at the request address.
- R3: Operation code 2 (chip erase) produces the same first five cycles as R2, and its sixth cycle writes 10h to address 5555h.
- R4: After the writes, the block repeats reads of the request address until bit 7 of every selected lane equals the expected value. The expected value is bit 7 of the request data for a program and 1 for either erase. Done then pulses with the error flag low, after exactly one read beyond the last read that showed the wrong value.
- R5: Chip select n (bit n of the select bus, active low) is asserted during an operation only when bit n of the lane mask is set. Lane n is data bits 8n+7..8n. The command byte appears on every selected lane. Bit 7 on unselected lanes has no effect on completion.
- R6: Every write-enable low pulse lasts exactly ceil(max(50, 50, 50 ns)/clock) = 5 cycles. Write enable stays high at least ceil(20 ns/clock) = 2 cycles between pulses. Address and data are steady and the data bus is driven for the whole low pulse.
- R7: Output enable stays high for at least ceil(10 ns/clock) = 1 cycle before each polling read. It is never low while write enable is low or while the data bus is driven.
- R8: If the operation is still incomplete at the first evaluation after the timeout count, done pulses with the error flag high. The count is ceil(300 us/clock) for a program, 15 s for a sector erase and 256 s for a chip erase, measured from the first polling cycle. The error flag clears when the next request is accepted.
- R9: Operation code 3 (reset) drives the flash reset line low for exactly ceil(500 ns/clock) cycles, with all chip selects high and no write cycle. Done then follows ceil(20 us/clock) cycles after the reset line rises.
- R10: After reset, busy, done, err and the acknowledge are low, and write enable, output enable, the flash reset line and all chip selects are high. A request taken in the idle state gives a one-cycle acknowledge together with busy high. Done is a single-cycle pulse, and busy is low when it occurs.
- R11: A request presented while busy is high is neither acknowledged nor executed. The ongoing operation's bus cycles are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_op | input | 2 | Operation code: 0 program, 1 sector erase, 2 chip erase, 3 reset |
| req_addr | input | 23 | Target byte address (program address or sector address) |
| req_data | input | 8 | Byte to program |
| req_lanes | input | 4 | Byte lanes the operation applies to |
| req_ack | output | 1 | One-cycle pulse when a request is accepted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation timed out; valid from done until next accept |
| fl_addr | output | 23 | Flash address bus |
| fl_dout | output | 32 | Data driven toward the flash |
| fl_din | input | 32 | Data read from the flash |
| fl_drv | output | 1 | Enable for the data bus drivers |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_cs_n | output | 4 | Per-lane chip selects, active low |
| fl_rst_n | output | 1 | Flash reset, active low |

## Verification
A wrong write index or operation latch shows up within one write cycle as a wrong address or byte on the bus. The bench catches it by recording every write-enable rising edge and comparing the recorded cycles against the sequence for each operation code. A wrong phase count shows up as a write-enable pulse of the wrong length, or a reset pulse of the wrong length, at the very first pulse. A wrong lane mask or expected-bit selection shows up after the first polling read: the read count is wrong, or done comes early, because the bench drives the wrong polarity on lanes outside the mask. A broken timeout compare shows up only after the full program timeout, as a missing error flag or a done outside its expected window.

// File: rtl/nfs_pkg.sv
`timescale 1ns/1ps
package nfs_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RST  = 2'd3
  } nfs_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WLO,
    S_WHI,
    S_GAP,
    S_RD,
    S_EVAL,
    S_RLO,
    S_RWAIT
  } nfs_st_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic longint us2cyc(input longint us, input int clk_ns);
    return (us * 1000 + longint'(clk_ns) - 1) / longint'(clk_ns);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nfs_cmd_gen.sv
`timescale 1ns/1ps
module nfs_cmd_gen
  import nfs_pkg::*;
#(
  parameter int AW = 23,
  parameter int LW = 8
) (
  input  nfs_op_e         op,
  input  logic [2:0]      idx,
  input  logic [AW-1:0]   addr,
  input  logic [LW-1:0]   data,
  output logic [AW-1:0]   c_addr,
  output logic [LW-1:0]   c_data,
  output logic            last
);
  localparam logic [AW-1:0] UNL_A = AW'(16'h5555);
  localparam logic [AW-1:0] UNL_B = AW'(16'h2AAA);

  always_comb begin
    c_addr = UNL_A;
    c_data = LW'(8'hAA);
    unique case (idx)
      3'd0: begin c_addr = UNL_A; c_data = LW'(8'hAA); end
      3'd1: begin c_addr = UNL_B; c_data = LW'(8'h55); end
      3'd2: begin
        c_addr = UNL_A;
        c_data = (op == OP_PROG) ? LW'(8'hA0) : LW'(8'h80);
      end
      3'd3: begin
        c_addr = (op == OP_PROG) ? addr : UNL_A;
        c_data = (op == OP_PROG) ? data : LW'(8'hAA);
      end
      3'd4: begin c_addr = UNL_B; c_data = LW'(8'h55); end
      default: begin
        c_addr = (op == OP_CHIP) ? UNL_A : addr;
        c_data = (op == OP_CHIP) ? LW'(8'h10) : LW'(8'h30);
      end
    endcase
  end

  assign last = (op == OP_PROG) ? (idx == 3'd3) : (idx == 3'd5);

endmodule

// File: rtl/nfs_lane_poll.sv
`timescale 1ns/1ps
module nfs_lane_poll #(
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic [LANES*LW-1:0] rd,
  input  logic [LANES-1:0]    sel,
  input  logic                exp_bit,
  output logic                match
);
  logic [LANES-1:0] lane_ok;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_unused;
    assign lane_unused = ^rd[l*LW +: LW-1];
    assign lane_ok[l]  = !sel[l] || (rd[l*LW + LW-1] == exp_bit);
  end

  assign match = &lane_ok;

endmodule

// File: rtl/nfs_seq.sv
`timescale 1ns/1ps
module nfs_seq
  import nfs_pkg::*;
#(
  parameter int     AW          = 23,
  parameter int     LANES       = 4,
  parameter int     LW          = 8,
  parameter int     CLK_NS      = 10,
  parameter int     WP_NS       = 50,
  parameter int     WPH_NS      = 20,
  parameter int     DS_NS       = 50,
  parameter int     AH_NS       = 50,
  parameter int     OEH_NS      = 10,
  parameter int     ACC_NS      = 100,
  parameter int     RP_NS       = 500,
  parameter int     RDY_NS      = 20000,
  parameter longint PROG_TMO_US = 300,
  parameter longint SECT_TMO_US = 15_000_000,
  parameter longint CHIP_TMO_US = 256_000_000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [AW-1:0]       req_addr,
  input  logic [LW-1:0]       req_data,
  input  logic [LANES-1:0]    req_lanes,
  output logic                req_ack,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [AW-1:0]       fl_addr,
  output logic [LANES*LW-1:0] fl_dout,
  input  logic [LANES*LW-1:0] fl_din,
  output logic                fl_drv,
  output logic                fl_we_n,
  output logic                fl_oe_n,
  output logic [LANES-1:0]    fl_cs_n,
  output logic                fl_rst_n
);
  localparam int DW    = LANES * LW;
  localparam int T_WLO = ns2cyc(imax(WP_NS, imax(DS_NS, AH_NS)), CLK_NS);
  localparam int T_WHI = ns2cyc(WPH_NS, CLK_NS);
  localparam int T_OEH = ns2cyc(OEH_NS, CLK_NS);
  localparam int T_ACC = ns2cyc(ACC_NS, CLK_NS);
  localparam int T_RP  = ns2cyc(RP_NS, CLK_NS);
  localparam int T_RDY = ns2cyc(RDY_NS, CLK_NS);
  localparam int PMAX  = imax(imax(T_WLO, T_WHI), imax(imax(T_OEH, T_ACC), imax(T_RP, T_RDY)));
  localparam int PW    = $clog2(PMAX + 1);
  localparam longint T_PROG = us2cyc(PROG_TMO_US, CLK_NS);
  localparam longint T_SECT = us2cyc(SECT_TMO_US, CLK_NS);
  localparam longint T_CHIP = us2cyc(CHIP_TMO_US, CLK_NS);
  localparam longint T_MAX  = (T_PROG > T_SECT) ? ((T_PROG > T_CHIP) ? T_PROG : T_CHIP)
                                                : ((T_SECT > T_CHIP) ? T_SECT : T_CHIP);
  localparam int TW = $clog2(T_MAX + 2);

  nfs_st_e          state;
  nfs_op_e          op_q;
  logic [AW-1:0]    addr_q;
  logic [LW-1:0]    data_q;
  logic [LANES-1:0] lanes_q;
  logic [2:0]       idx_q;
  logic [PW-1:0]    cnt_q;
  logic [TW-1:0]    tmo_q;
  logic [DW-1:0]    rd_q;
  logic [PW-1:0]    lim_m1;
  logic             phase_end;
  logic [TW-1:0]    tmo_lim;
  logic [AW-1:0]    c_addr;
  logic [LW-1:0]    c_data;
  logic             c_last;
  logic             poll_ok;
  logic             exp_bit;

  nfs_cmd_gen #(.AW(AW), .LW(LW)) u_cmd (
    .op(op_q), .idx(idx_q), .addr(addr_q), .data(data_q),
    .c_addr(c_addr), .c_data(c_data), .last(c_last)
  );

  assign exp_bit = (op_q == OP_PROG) ? data_q[LW-1] : 1'b1;

  nfs_lane_poll #(.LANES(LANES), .LW(LW)) u_poll (
    .rd(rd_q), .sel(lanes_q), .exp_bit(exp_bit), .match(poll_ok)
  );

  always_comb begin
    unique case (state)
      S_WLO:   lim_m1 = PW'(T_WLO - 1);
      S_WHI:   lim_m1 = PW'(T_WHI - 1);
      S_GAP:   lim_m1 = PW'(T_OEH - 1);
      S_RD:    lim_m1 = PW'(T_ACC - 1);
      S_RLO:   lim_m1 = PW'(T_RP - 1);
      S_RWAIT: lim_m1 = PW'(T_RDY - 1);
      default: lim_m1 = '0;
    endcase
  end
  assign phase_end = (cnt_q == lim_m1);

  always_comb begin
    unique case (op_q)
      OP_SECT: tmo_lim = TW'(T_SECT);
      OP_CHIP: tmo_lim = TW'(T_CHIP);
      default: tmo_lim = TW'(T_PROG);
    endcase
  end

  // Bus pins decoded from the single state register
  assign fl_we_n  = (state != S_WLO);
  assign fl_oe_n  = (state != S_RD);
  assign fl_drv   = (state == S_WLO) || (state == S_WHI);
  assign fl_rst_n = (state != S_RLO);
  assign fl_cs_n  = (state inside {S_WLO, S_WHI, S_GAP, S_RD, S_EVAL}) ? ~lanes_q : '1;
  assign fl_addr  = fl_drv ? c_addr : addr_q;
  assign fl_dout  = {LANES{c_data}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      lanes_q <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      tmo_q   <= '0;
      rd_q    <= '0;
      req_ack <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      req_ack <= 1'b0;
      done    <= 1'b0;
      if (state inside {S_WLO, S_WHI, S_GAP, S_RD, S_RLO, S_RWAIT})
        cnt_q <= phase_end ? '0 : cnt_q + 1'b1;
      else
        cnt_q <= '0;
      if (state inside {S_GAP, S_RD, S_EVAL})
        tmo_q <= tmo_q + 1'b1;
      else
        tmo_q <= '0;

      unique case (state)
        S_IDLE: if (req_valid) begin
          op_q    <= nfs_op_e'(req_op);
          addr_q  <= req_addr;
          data_q  <= req_data;
          lanes_q <= req_lanes;
          idx_q   <= '0;
          req_ack <= 1'b1;
          busy    <= 1'b1;
          err     <= 1'b0;
          state   <= (nfs_op_e'(req_op) == OP_RST) ? S_RLO : S_WLO;
        end
        S_WLO: if (phase_end) state <= S_WHI;
        S_WHI: if (phase_end) begin
          if (c_last) state <= S_GAP;
          else begin
            idx_q <= idx_q + 1'b1;
            state <= S_WLO;
          end
        end
        S_GAP: if (phase_end) state <= S_RD;
        S_RD: if (phase_end) begin
          rd_q  <= fl_din;
          state <= S_EVAL;
        end
        S_EVAL: begin
          if (poll_ok || tmo_q >= tmo_lim) begin
            done  <= 1'b1;
            err   <= !poll_ok;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            state <= S_GAP;
          end
        end
        S_RLO: if (phase_end) state <= S_RWAIT;
        S_RWAIT: if (phase_end) begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Checks on the generated bus waveform
  logic [PW-1:0] wlo_run;
  always_ff @(posedge clk) begin
    if (rst) wlo_run <= '0;
    else if (!fl_we_n) wlo_run <= wlo_run + 1'b1;
    else wlo_run <= '0;
  end

  // R6
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (wlo_run >= PW'(T_WLO)));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout) && fl_drv));

  // R7
  oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> (fl_we_n && !fl_drv));

  // R9
  rst_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_rst_n |-> (fl_cs_n == '1));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));

  // R11
  ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (busy && !$past(busy)));

endmodule

// File: tb/nfs_seq_test.sv
`timescale 1ns/1ps
module nfs_seq_test;
  localparam int     T_WLO  = 5;
  localparam int     T_WHI  = 2;
  localparam int     T_OEH  = 1;
  localparam int     T_ACC  = 10;
  localparam int     T_RP   = 50;
  localparam int     T_RDY  = 2000;
  localparam longint T_PROG = 30000;
  localparam int     PERIOD = T_OEH + T_ACC + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [22:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [3:0]  req_lanes = '0;
  logic        req_ack, busy, done, err;
  logic [22:0] fl_addr;
  logic [31:0] fl_dout, fl_din;
  logic        fl_drv, fl_we_n, fl_oe_n, fl_rst_n;
  logic [3:0]  fl_cs_n;

  always #5 clk = ~clk;

  nfs_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_lanes(req_lanes),
    .req_ack(req_ack), .busy(busy), .done(done), .err(err),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din), .fl_drv(fl_drv),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_cs_n(fl_cs_n), .fl_rst_n(fl_rst_n)
  );

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Flash response model
  logic [3:0] tb_sel = '0;
  logic       tb_exp = 1'b0;
  int         n_busy = 0;

  // Bus monitor state
  int          cyc = 0, wr_cnt = 0, lo_run = 0, hi_run = 0, min_lo = 0, max_lo = 0, min_hi = 0;
  int          rd_cnt = 0, oe_hi = 0, min_gap = 0, stab_bad = 0, cs_bad = 0;
  int          rlo = 0, rst_rise_t = 0, last_we_t = 0;
  logic [22:0] lo_addr = '0;
  logic [31:0] lo_dat = '0;
  logic        oe_prev = 1'b1, rst_prev = 1'b1;
  logic [22:0] wr_addr [8];
  logic [31:0] wr_data [8];
  logic [3:0]  wr_cs   [8];

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      fl_din[l*8 +: 7] = 7'h35;
      fl_din[l*8 + 7]  = (rd_cnt <= n_busy || !tb_sel[l]) ? ~tb_exp : tb_exp;
    end
  end

  task automatic mon_clear();
    wr_cnt = 0; lo_run = 0; hi_run = 0; min_lo = 1000; max_lo = 0; min_hi = 1000;
    rd_cnt = 0; oe_hi = 0; min_gap = 1000; stab_bad = 0; cs_bad = 0; rlo = 0;
    rst_rise_t = 0; last_we_t = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!fl_we_n) begin
      if (lo_run == 0) begin
        if (wr_cnt > 0 && hi_run < min_hi) min_hi = hi_run;
        hi_run = 0;
      end else if (fl_addr != lo_addr || fl_dout != lo_dat) begin
        stab_bad++;
      end
      if (!fl_drv) stab_bad++;
      lo_run++;
      lo_addr = fl_addr;
      lo_dat  = fl_dout;
    end else begin
      if (lo_run > 0) begin
        if (wr_cnt < 8) begin
          wr_addr[wr_cnt] = lo_addr;
          wr_data[wr_cnt] = lo_dat;
          wr_cs[wr_cnt]   = fl_cs_n;
        end
        wr_cnt++;
        if (lo_run < min_lo) min_lo = lo_run;
        if (lo_run > max_lo) max_lo = lo_run;
        last_we_t = cyc;
      end
      lo_run = 0;
      hi_run++;
    end
    if (!fl_oe_n && oe_prev) begin
      rd_cnt++;
      if (oe_hi < min_gap) min_gap = oe_hi;
    end
    oe_hi   = fl_oe_n ? oe_hi + 1 : 0;
    oe_prev = fl_oe_n;
    if (!fl_rst_n) begin
      rlo++;
      if (fl_cs_n != 4'hF) cs_bad++;
    end
    if (fl_rst_n && !rst_prev) rst_rise_t = cyc;
    rst_prev = fl_rst_n;
  end

  function automatic void exp_cyc(input int op, input int k, input logic [22:0] a,
                                  input logic [7:0] d, output logic [22:0] ea,
                                  output logic [7:0] ed);
    ea = ((k % 3) == 1) ? 23'h2AAA : 23'h5555;
    ed = ((k % 3) == 1) ? 8'h55 : 8'hAA;
    if (k == 2) ed = (op == 0) ? 8'hA0 : 8'h80;
    if (op == 0 && k == 3) begin ea = a; ed = d; end
    if (k == 5) begin
      ea = (op == 2) ? 23'h5555 : a;
      ed = (op == 2) ? 8'h10 : 8'h30;
    end
  endfunction

  int   done_t = 0;
  logic done_err = 1'b0;
  int   ack_bad = 0;

  // Issue one request, optionally pester with requests while busy, wait for done
  task automatic run_op(input int op, input logic [22:0] a, input logic [7:0] d,
                        input logic [3:0] lanes, input int nb, input bit exp_b,
                        input bit pester);
    int t;
    @(posedge clk);
    mon_clear();
    tb_sel = lanes; tb_exp = exp_b; n_busy = nb; ack_bad = 0;
    @(negedge clk); #1;
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d; req_lanes = lanes;
    @(negedge clk); #1;
    chk(req_ack === 1'b1 && busy === 1'b1, "R10", "ack and busy after accept",
        {req_ack, busy}, 3);
    req_valid = 1'b0;
    if (pester) begin
      req_valid = 1'b1; req_op = 2'd2; req_addr = 23'h7AAAA; req_data = 8'hC3; req_lanes = 4'hF;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); #1;
        if (req_ack) ack_bad++;
      end
      req_valid = 1'b0;
    end
    t = 0;
    while (done !== 1'b1 && t < 60000) begin
      @(negedge clk); #1;
      t++;
    end
    done_t = cyc;
    done_err = err;
    chk(done === 1'b1 && busy === 1'b0, "R10", "done pulse with busy low", {done, busy}, 2);
    @(negedge clk); #1;
    chk(done === 1'b0, "R10", "done lasts one cycle", done, 0);
  endtask

  task automatic check_writes(input int op, input logic [22:0] a, input logic [7:0] d,
                              input logic [3:0] lanes, input string req);
    int n;
    int bad;
    int csbad;
    logic [22:0] ea;
    logic [7:0]  ed;
    n = (op == 0) ? 4 : 6;
    chk(wr_cnt == n, req, "write cycle count", wr_cnt, n);
    bad = 0; csbad = 0;
    for (int k = 0; k < n && k < wr_cnt; k++) begin
      exp_cyc(op, k, a, d, ea, ed);
      if (wr_addr[k] !== ea) bad++;
      for (int l = 0; l < 4; l++)
        if (lanes[l] && wr_data[k][l*8 +: 8] !== ed) bad++;
      if (wr_cs[k] !== ~lanes) csbad++;
    end
    chk(bad == 0, req, "write address/data mismatches", bad, 0);
    chk(csbad == 0, "R5", "chip selects during writes", csbad, 0);
    chk(min_lo == T_WLO && max_lo == T_WLO, "R6", "write enable low width", min_lo, T_WLO);
    chk(min_hi >= T_WHI, "R6", "write enable high gap", min_hi, T_WHI);
    chk(stab_bad == 0, "R6", "bus changes during low pulse", stab_bad, 0);
  endtask

  initial begin
    #1_500_000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk({busy, done, err, req_ack} === 4'b0000, "R10", "host outputs in reset", {busy, done, err, req_ack}, 0);
    chk({fl_we_n, fl_oe_n, fl_rst_n, fl_cs_n} === 7'h7F, "R10", "bus idle in reset",
        {fl_we_n, fl_oe_n, fl_rst_n, fl_cs_n}, 7'h7F);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1, R4, R5: program sweep over every non-empty lane mask
    for (int m = 1; m < 16; m++) begin
      logic [22:0] a;
      logic [7:0]  d;
      a = 23'h100000 + 23'(m * 37);
      d = {4'(m), ~4'(m)};
      run_op(0, a, d, 4'(m), m % 3, d[7], 1'b0);
      check_writes(0, a, d, 4'(m), "R1");
      chk(rd_cnt == (m % 3) + 1, "R4", "program poll reads", rd_cnt, (m % 3) + 1);
      chk(done_err == 1'b0, "R4", "no error on completion", done_err, 0);
      chk(min_gap >= T_OEH, "R7", "output enable high before read", min_gap, T_OEH);
    end

    // R2: sector erase, lanes 0 and 2
    run_op(1, 23'h3F0000, 8'h00, 4'b0101, 3, 1'b1, 1'b0);
    check_writes(1, 23'h3F0000, 8'h00, 4'b0101, "R2");
    chk(rd_cnt == 4, "R4", "sector erase poll reads", rd_cnt, 4);
    chk(done_err == 1'b0, "R4", "sector erase no error", done_err, 0);

    // R3: chip erase, all lanes
    run_op(2, 23'h000123, 8'h00, 4'hF, 2, 1'b1, 1'b0);
    check_writes(2, 23'h000123, 8'h00, 4'hF, "R3");
    chk(rd_cnt == 3, "R4", "chip erase poll reads", rd_cnt, 3);

    // R11: requests while busy are ignored
    run_op(0, 23'h0ABCDE, 8'h5A, 4'b0010, 1, 1'b0, 1'b1);
    chk(ack_bad == 0, "R11", "acks while busy", ack_bad, 0);
    check_writes(0, 23'h0ABCDE, 8'h5A, 4'b0010, "R11");
    chk(busy === 1'b0, "R11", "idle after ignored request", busy, 0);

    // R8: program that never completes
    run_op(0, 23'h012345, 8'h80, 4'b1000, 1_000_000, 1'b1, 1'b0);
    chk(done_err == 1'b1, "R8", "timeout error flag", done_err, 1);
    chk(done_t - last_we_t >= T_PROG, "R8", "timeout not early", done_t - last_we_t, T_PROG);
    chk(done_t - last_we_t <= T_PROG + T_WHI + PERIOD + 3, "R8", "timeout not late",
        done_t - last_we_t, T_PROG + T_WHI + PERIOD + 3);
    chk(err === 1'b1, "R8", "error flag held after done", err, 1);
    run_op(0, 23'h012345, 8'h01, 4'b1000, 0, 1'b0, 1'b0);
    chk(done_err == 1'b0, "R8", "error cleared by next request", done_err, 0);

    // R9: reset operation
    run_op(3, 23'h0, 8'h0, 4'hF, 0, 1'b1, 1'b0);
    chk(rlo == T_RP, "R9", "reset low width", rlo, T_RP);
    chk(done_t - rst_rise_t >= T_RDY && done_t - rst_rise_t <= T_RDY + 2, "R9",
        "reset recovery wait", done_t - rst_rise_t, T_RDY);
    chk(wr_cnt == 0 && cs_bad == 0, "R9", "no writes or selects in reset", wr_cnt + cs_bad, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule